// File: doc/BRIEF.md
# Charging Port Mode Controller

This block is the digital heart of a USB charging port. It watches a four-bit control code, an enable and a power-on reset, and from them derives the port's charging personality, whether the high or low current limit applies, whether the data-line switches connect the connector to the host, whether the VBUS power switch is on, and when VBUS must be discharged.

Mode changes are sequenced. Most changes first pull VBUS down for a programmable discharge interval. During this interval the power switch is off and the data lines are open. Only then does the new mode appear. The pair "data port with charging handshake" and "plain data port, low limit" are the exception: the port moves between them silently.

Two pieces of supporting logic complete the block. A filter rejects control codes that do not hold steady. A recovery sequence helps phones that wrongly treat a charging data port as a charge-only port. For such a phone, the block discharges VBUS, presents a plain data port for a while, and then silently returns to the charging data port.

Top module: `chgport_mode_ctrl`

## Requirements
- R1: The control code is read as {c1,c2,c3,sel} in bits [3:2:1:0]. The decode is: c1c2c3 = 000 gives mode 0 (discharge); c1=0 with c3=1 gives mode 1 (auto-detect charger); c2c3 = 10 gives mode 2 (data port A); 100 gives mode 3 (shorted charger); 101 gives mode 4 (divider charger); 1110 gives mode 5 (data port B); 1111 gives mode 6 (charging data port).
- R2: While por_n is low, the outputs are discharge=1, pwr_sw_en=0, data_sw_en=0 and mode_o=0. After release, one full discharge interval runs before the mode chosen by the code appears.
- R3: ilim_hi is 1 in modes 1 and 6 and 0 in modes 0 and 5. In modes 2, 3 and 4 it follows sel. It is 0 whenever discharge is 1.
- R4: A change between mode 5 and mode 6 happens without discharge. pwr_sw_en and data_sw_en stay at 1 throughout.
- R5: Any other change of mode first asserts discharge for DCHG_TICKS cycles. During that time pwr_sw_en=0, data_sw_en=0 and mode_o=0.
- R6: A change of sel that keeps the same mode only updates ilim_hi, with no discharge.
- R7: data_sw_en is 1 only in modes 2, 5 and 6, with enable high and no discharge in progress.
- R8: A low en_in forces discharge=1, pwr_sw_en=0 and data_sw_en=0 within SYNC_STAGES+1 cycles. After en_in returns high, a full discharge interval runs before power returns.
- R9: A code that holds for fewer than STABLE_TICKS consecutive synchronised samples is ignored.
- R10: While wake_hold is 1, a request for mode 1 made from mode 2, 5 or 6 is ignored. Mode, limit and data switches stay as they were. Releasing wake_hold lets the request proceed.
- R11: In mode 6, a rising dcp_nodata causes a discharge interval, then mode 5 for HOLD_TICKS cycles, then a silent return to mode 6. The recovery re-arms only after dcp_nodata has been low.
- R12: Code 000x holds discharge=1 and pwr_sw_en=0 for as long as it stays applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| en_in | input | 1 | Port enable, asynchronous to clk |
| ctl_code | input | 4 | Control code {c1,c2,c3,sel}, asynchronous to clk |
| wake_hold | input | 1 | Wake classifier asks to keep the data connection |
| dcp_nodata | input | 1 | Phone took the port for a charge-only port and made no data connection |
| mode_o | output | 3 | Current mode code (R1 encoding) |
| ilim_hi | output | 1 | 1 selects the high current limit |
| data_sw_en | output | 1 | Data-line switch enable |
| pwr_sw_en | output | 1 | VBUS power switch enable |
| discharge | output | 1 | VBUS discharge active |

## Verification
A code change reaches the sequencer after SYNC_STAGES synchroniser flops plus STABLE_TICKS filter samples, and acts on the next edge. With the bench settings (2 and 4), a result is due 7 cycles after the drive, and a discharge interval ends at most 47 cycles after the drive. An enable change reaches the outputs after two flops. The recovery sequence is counted exactly: discharge on cycles 1 to 40 after the flag, port B on cycles 41 to 60, then mode 6. Each expectation is queued with the cycle in which it is due. Checks fall well inside these windows (10 cycles for first effects, 60 for settled modes). Checks repeated at several cycles inside a window confirm that silent changes never raise discharge.

// File: rtl/chgport_pkg.sv
package chgport_pkg;

   typedef enum logic [2:0] {
      MD_DCHG      = 3'd0,
      MD_DCP_AUTO  = 3'd1,
      MD_SDP1      = 3'd2,
      MD_DCP_SHORT = 3'd3,
      MD_DIV1A     = 3'd4,
      MD_SDP2      = 3'd5,
      MD_CDP       = 3'd6
   } chg_mode_e;

   typedef struct packed {
      chg_mode_e mode;
      logic      hi;
   } mode_sel_t;

   function automatic logic is_data_mode(chg_mode_e m);
      return (m == MD_SDP1) || (m == MD_SDP2) || (m == MD_CDP);
   endfunction

   function automatic logic is_silent_pair(chg_mode_e a, chg_mode_e b);
      return ((a == MD_SDP2) && (b == MD_CDP)) || ((a == MD_CDP) && (b == MD_SDP2));
   endfunction

endpackage

// File: rtl/chgport_sync.sv
module chgport_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stg[g] <= '0;
               else        stg[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge por_n) begin
               if (!por_n) stg[g] <= '0;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/chgport_debounce.sv
module chgport_debounce #(
   parameter int W            = 4,
   parameter int STABLE_TICKS = 16
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CW = $clog2(STABLE_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

   logic [W-1:0]  cand;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         q    <= '0;
         cand <= '0;
         cnt  <= '0;
      end else if (d == q) begin
         cnt <= '0;
      end else if (d != cand) begin
         cand <= d;
         cnt  <= CW'(1);
      end else if (cnt >= LAST) begin
         q   <= d;
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/chgport_decode.sv
module chgport_decode
   import chgport_pkg::*;
(
   input  logic [3:0] code,
   output mode_sel_t  sel
);
   logic isel;
   assign isel = code[0];

   always_comb begin
      sel.mode = MD_DCHG;
      sel.hi   = 1'b0;
      case (code[3:1])
         3'b000: begin sel.mode = MD_DCHG;      sel.hi = 1'b0; end
         3'b001,
         3'b011: begin sel.mode = MD_DCP_AUTO;  sel.hi = 1'b1; end
         3'b010,
         3'b110: begin sel.mode = MD_SDP1;      sel.hi = isel; end
         3'b100: begin sel.mode = MD_DCP_SHORT; sel.hi = isel; end
         3'b101: begin sel.mode = MD_DIV1A;     sel.hi = isel; end
         3'b111: begin
            sel.mode = isel ? MD_CDP : MD_SDP2;
            sel.hi   = isel;
         end
         default: begin sel.mode = MD_DCHG;     sel.hi = 1'b0; end
      endcase
   end
endmodule

// File: rtl/chgport_seq.sv
module chgport_seq
   import chgport_pkg::*;
#(
   parameter int DCHG_TICKS = 500_000_000,
   parameter int HOLD_TICKS = 25_000_000
) (
   input  logic      clk,
   input  logic      por_n,
   input  logic      en_s,
   input  mode_sel_t req,
   input  logic      wake_hold,
   input  logic      dcp_nodata,
   output chg_mode_e mode_o,
   output logic      ilim_hi,
   output logic      data_sw_en,
   output logic      pwr_sw_en,
   output logic      discharge
);
   localparam int TMAX = (DCHG_TICKS > HOLD_TICKS) ? DCHG_TICKS : HOLD_TICKS;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] DCHG_LOAD = TW'(DCHG_TICKS - 1);
   localparam logic [TW-1:0] HOLD_LOAD = TW'(HOLD_TICKS - 1);

   typedef enum logic [1:0] {ST_DCHG, ST_RUN, ST_HOLD} st_e;

   st_e       st;
   chg_mode_e cur_m;
   logic      cur_hi;
   logic [TW-1:0] tmr;
   logic      asw_pend;
   logic      asw_armed;

   logic      keep;
   chg_mode_e tgt_m;
   logic      tgt_hi;
   logic      asw_fire;
   logic      in_dchg;

   always_comb begin
      keep     = wake_hold && (req.mode == MD_DCP_AUTO) && is_data_mode(cur_m);
      tgt_m    = keep ? cur_m  : req.mode;
      tgt_hi   = keep ? cur_hi : req.hi;
      asw_fire = (st == ST_RUN) && en_s && (cur_m == MD_CDP) && (tgt_m == MD_CDP)
                 && dcp_nodata && asw_armed;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st        <= ST_DCHG;
         tmr       <= DCHG_LOAD;
         cur_m     <= MD_DCHG;
         cur_hi    <= 1'b0;
         asw_pend  <= 1'b0;
         asw_armed <= 1'b1;
      end else begin
         if (asw_fire)         asw_armed <= 1'b0;
         else if (!dcp_nodata) asw_armed <= 1'b1;

         case (st)
            ST_RUN: begin
               if (!en_s) begin
                  st       <= ST_DCHG;
                  tmr      <= DCHG_LOAD;
                  asw_pend <= 1'b0;
               end else if (asw_fire) begin
                  st       <= ST_DCHG;
                  tmr      <= DCHG_LOAD;
                  asw_pend <= 1'b1;
               end else if (tgt_m == cur_m) begin
                  cur_hi <= tgt_hi;
               end else if (is_silent_pair(cur_m, tgt_m)) begin
                  cur_m  <= tgt_m;
                  cur_hi <= tgt_hi;
               end else begin
                  st       <= ST_DCHG;
                  tmr      <= DCHG_LOAD;
                  asw_pend <= 1'b0;
               end
            end
            ST_DCHG: begin
               if (!en_s) begin
                  tmr      <= DCHG_LOAD;
                  asw_pend <= 1'b0;
               end else if (tmr == '0) begin
                  asw_pend <= 1'b0;
                  if (asw_pend && (tgt_m == MD_CDP)) begin
                     st     <= ST_HOLD;
                     tmr    <= HOLD_LOAD;
                     cur_m  <= MD_SDP2;
                     cur_hi <= 1'b0;
                  end else begin
                     st     <= ST_RUN;
                     cur_m  <= tgt_m;
                     cur_hi <= tgt_hi;
                  end
               end else begin
                  tmr <= tmr - TW'(1);
               end
            end
            ST_HOLD: begin
               if (!en_s) begin
                  st  <= ST_DCHG;
                  tmr <= DCHG_LOAD;
               end else if (tgt_m != MD_CDP) begin
                  st <= ST_RUN;
               end else if (tmr == '0) begin
                  st     <= ST_RUN;
                  cur_m  <= MD_CDP;
                  cur_hi <= 1'b1;
               end else begin
                  tmr <= tmr - TW'(1);
               end
            end
            default: begin
               st  <= ST_DCHG;
               tmr <= DCHG_LOAD;
            end
         endcase
      end
   end

   always_comb begin
      in_dchg    = (st == ST_DCHG) || !en_s;
      discharge  = in_dchg || (cur_m == MD_DCHG);
      pwr_sw_en  = !discharge;
      data_sw_en = !in_dchg && is_data_mode(cur_m);
      mode_o     = in_dchg ? MD_DCHG : cur_m;
      ilim_hi    = !discharge && cur_hi;
   end
endmodule

// File: rtl/chgport_mode_ctrl.sv
module chgport_mode_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter int STABLE_TICKS = 16,
   parameter int DCHG_TICKS   = 500_000_000,
   parameter int HOLD_TICKS   = 25_000_000
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       en_in,
   input  logic [3:0] ctl_code,
   input  logic       wake_hold,
   input  logic       dcp_nodata,
   output logic [2:0] mode_o,
   output logic       ilim_hi,
   output logic       data_sw_en,
   output logic       pwr_sw_en,
   output logic       discharge
);
   import chgport_pkg::*;

   localparam int CODE_W = 4;
   localparam int SYNC_W = CODE_W + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STABLE_TICKS < 2) begin : g_bad_stable
         $error("STABLE_TICKS must be at least 2");
      end
      if (DCHG_TICKS < 2 || HOLD_TICKS < 2) begin : g_bad_timer
         $error("DCHG_TICKS and HOLD_TICKS must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] sync_q;
   logic              en_s;
   logic [CODE_W-1:0] code_s;
   logic [CODE_W-1:0] code_f;
   mode_sel_t         req;
   chg_mode_e         mode_e;

   chgport_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     ({en_in, ctl_code}),
      .q     (sync_q)
   );

   assign en_s   = sync_q[SYNC_W-1];
   assign code_s = sync_q[CODE_W-1:0];

   chgport_debounce #(.W(CODE_W), .STABLE_TICKS(STABLE_TICKS)) u_filt (
      .clk   (clk),
      .por_n (por_n),
      .d     (code_s),
      .q     (code_f)
   );

   chgport_decode u_dec (
      .code (code_f),
      .sel  (req)
   );

   chgport_seq #(.DCHG_TICKS(DCHG_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_seq (
      .clk        (clk),
      .por_n      (por_n),
      .en_s       (en_s),
      .req        (req),
      .wake_hold  (wake_hold),
      .dcp_nodata (dcp_nodata),
      .mode_o     (mode_e),
      .ilim_hi    (ilim_hi),
      .data_sw_en (data_sw_en),
      .pwr_sw_en  (pwr_sw_en),
      .discharge  (discharge)
   );

   assign mode_o = mode_e;
endmodule

// File: rtl/chgport_mode_ctrl_chk.sv
module chgport_mode_ctrl_chk #(
   parameter int DCHG_TICKS = 500_000_000
) (
   input logic       clk,
   input logic       por_n,
   input logic       en_s,
   input logic [2:0] mode_o,
   input logic       ilim_hi,
   input logic       data_sw_en,
   input logic       pwr_sw_en,
   input logic       discharge
);
   import chgport_pkg::*;

   localparam logic [2:0] M0 = 3'(MD_DCHG);
   localparam logic [2:0] M1 = 3'(MD_DCP_AUTO);
   localparam logic [2:0] M2 = 3'(MD_SDP1);
   localparam logic [2:0] M5 = 3'(MD_SDP2);
   localparam logic [2:0] M6 = 3'(MD_CDP);

   int unsigned dchg_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  dchg_run <= 0;
      else if (!discharge)         dchg_run <= 0;
      else if (dchg_run < 32'hFFFF_FFF0) dchg_run <= dchg_run + 1;
   end

   // R5: power returns only after a full discharge interval
   p_dchg_length_r5: assert property (@(posedge clk) disable iff (!por_n)
      $fell(discharge) |-> (dchg_run >= DCHG_TICKS));

   // R4: direct mode changes only within the silent pair
   p_silent_pair_r4: assert property (@(posedge clk) disable iff (!por_n)
      ((mode_o != $past(mode_o)) && (mode_o != M0) && ($past(mode_o) != M0))
      |-> (((mode_o == M5) && ($past(mode_o) == M6)) ||
           ((mode_o == M6) && ($past(mode_o) == M5))));

   // R3: limit selection per mode
   p_ilim_hi_modes_r3: assert property (@(posedge clk) disable iff (!por_n)
      ((mode_o == M6) || (mode_o == M1)) |-> ilim_hi);
   p_ilim_lo_modes_r3: assert property (@(posedge clk) disable iff (!por_n)
      ((mode_o == M5) || (mode_o == M0) || discharge) |-> !ilim_hi);

   // R7: data switches only in data modes without discharge
   p_data_only_data_r7: assert property (@(posedge clk) disable iff (!por_n)
      data_sw_en |-> (((mode_o == M2) || (mode_o == M5) || (mode_o == M6)) && !discharge));

   // R8: enable low forces the safe state
   p_en_low_safe_r8: assert property (@(posedge clk) disable iff (!por_n)
      !en_s |-> (discharge && !pwr_sw_en && !data_sw_en && (mode_o == M0)));
endmodule

bind chgport_mode_ctrl chgport_mode_ctrl_chk #(.DCHG_TICKS(DCHG_TICKS)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .en_s       (en_s),
   .mode_o     (mode_o),
   .ilim_hi    (ilim_hi),
   .data_sw_en (data_sw_en),
   .pwr_sw_en  (pwr_sw_en),
   .discharge  (discharge)
);

// File: tb/tb_chgport_mode_ctrl.sv
`timescale 1ns/1ps
module tb_chgport_mode_ctrl;

   localparam int SYNC = 2;
   localparam int STB  = 4;
   localparam int DCH  = 40;
   localparam int HLD  = 20;

   localparam logic [2:0] M0 = 3'd0, M1 = 3'd1, M2 = 3'd2, M3 = 3'd3,
                          M4 = 3'd4, M5 = 3'd5, M6 = 3'd6;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       en_in = 1'b1;
   logic [3:0] ctl_code = 4'b1111;
   logic       wake_hold = 1'b0;
   logic       dcp_nodata = 1'b0;
   logic [2:0] mode_o;
   logic       ilim_hi, data_sw_en, pwr_sw_en, discharge;

   always #2 clk = ~clk;

   chgport_mode_ctrl #(
      .SYNC_STAGES (SYNC),
      .STABLE_TICKS(STB),
      .DCHG_TICKS  (DCH),
      .HOLD_TICKS  (HLD)
   ) dut (
      .clk(clk), .por_n(por_n), .en_in(en_in), .ctl_code(ctl_code),
      .wake_hold(wake_hold), .dcp_nodata(dcp_nodata),
      .mode_o(mode_o), .ilim_hi(ilim_hi), .data_sw_en(data_sw_en),
      .pwr_sw_en(pwr_sw_en), .discharge(discharge)
   );

   typedef struct {
      longint     at;
      string      tag;
      bit         full;
      logic [2:0] m;
      logic       hi, data, pwr, dchg;
   } exp_t;

   exp_t   sbq[$];
   int     n_chk = 0;
   int     n_fail = 0;
   longint cyc = 0;
   bit     done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(input int dly, input string tag, input bit full,
                       input logic [2:0] m, input logic hi, input logic data,
                       input logic pwr, input logic dchg);
      exp_t e;
      int   idx;
      e.at = cyc + dly; e.tag = tag; e.full = full; e.m = m;
      e.hi = hi; e.data = data; e.pwr = pwr; e.dchg = dchg;
      idx = sbq.size();
      for (int i = 0; i < sbq.size(); i++) begin
         if (sbq[i].at > e.at) begin idx = i; break; end
      end
      sbq.insert(idx, e);
   endtask

   // monitor: pops due items and compares them
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
         exp_t e;
         bit   bad;
         e = sbq.pop_front();
         n_chk++;
         bad = (e.at != cyc) || (discharge !== e.dchg) || (pwr_sw_en !== e.pwr)
               || (data_sw_en !== e.data);
         if (e.full) bad = bad || (mode_o !== e.m) || (ilim_hi !== e.hi);
         if (bad) begin
            n_fail++;
            $display("FAIL %s cyc=%0d: act mode=%0d hi=%b data=%b pwr=%b dchg=%b exp mode=%0d hi=%b data=%b pwr=%b dchg=%b",
                     e.tag, cyc, mode_o, ilim_hi, data_sw_en, pwr_sw_en, discharge,
                     e.m, e.hi, e.data, e.pwr, e.dchg);
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic quiet_window(input string tag, input int from, input int upto,
                               input logic data);
      for (int k = from; k <= upto; k += 2) push(k, tag, 1'b0, M0, 1'b0, data, 1'b1, 1'b0);
   endtask

   initial begin
      #1;
      // R2: reset state
      push(2, "R2", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      wait_cyc(5);
      por_n = 1'b1;
      push(5,  "R2", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(30, "R2", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(70, "R2", 1'b1, M6, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_cyc(72);

      // R4: CDP -> SDP2 silently
      ctl_code = 4'b1110;
      quiet_window("R4", 1, 13, 1'b1);
      push(14, "R4", 1'b1, M5, 1'b0, 1'b1, 1'b1, 1'b0);
      wait_cyc(20);
      // R4: SDP2 -> CDP silently
      ctl_code = 4'b1111;
      quiet_window("R4", 1, 13, 1'b1);
      push(14, "R4", 1'b1, M6, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_cyc(20);

      // R5: CDP -> SDP1 with discharge
      ctl_code = 4'b1101;
      push(10, "R5", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(30, "R5", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(60, "R5", 1'b1, M2, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_cyc(62);

      // R6: limit change only
      ctl_code = 4'b1100;
      quiet_window("R6", 1, 11, 1'b1);
      push(12, "R6", 1'b1, M2, 1'b0, 1'b1, 1'b1, 1'b0);
      wait_cyc(20);

      // R10: wake hold keeps the data mode
      wake_hold = 1'b1;
      ctl_code  = 4'b0110;
      push(10, "R10", 1'b1, M2, 1'b0, 1'b1, 1'b1, 1'b0);
      push(30, "R10", 1'b1, M2, 1'b0, 1'b1, 1'b1, 1'b0);
      push(60, "R10", 1'b1, M2, 1'b0, 1'b1, 1'b1, 1'b0);
      wait_cyc(62);
      wake_hold = 1'b0;
      push(10, "R10", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(60, "R7",  1'b1, M1, 1'b1, 1'b0, 1'b1, 1'b0);
      wait_cyc(62);

      // R8: enable low
      en_in = 1'b0;
      push(4,  "R8", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(20, "R8", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      wait_cyc(22);
      en_in = 1'b1;
      push(4,  "R8", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(30, "R8", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(60, "R8", 1'b1, M1, 1'b1, 1'b0, 1'b1, 1'b0);
      wait_cyc(62);

      // R1: shorted charger and divider charger
      ctl_code = 4'b1000;
      push(60, "R1", 1'b1, M3, 1'b0, 1'b0, 1'b1, 1'b0);
      wait_cyc(62);
      ctl_code = 4'b1011;
      push(60, "R1", 1'b1, M4, 1'b1, 1'b0, 1'b1, 1'b0);
      wait_cyc(62);

      // R9: short glitch ignored
      push(10, "R9", 1'b1, M4, 1'b1, 1'b0, 1'b1, 1'b0);
      push(25, "R9", 1'b1, M4, 1'b1, 1'b0, 1'b1, 1'b0);
      ctl_code = 4'b1111;
      wait_cyc(2);
      ctl_code = 4'b1011;
      wait_cyc(28);

      // R12: discharge code holds
      ctl_code = 4'b0001;
      push(60,  "R12", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(150, "R12", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      wait_cyc(152);

      // R11: recovery sequence
      ctl_code = 4'b1111;
      push(60, "R11", 1'b1, M6, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_cyc(62);
      dcp_nodata = 1'b1;
      push(3,   "R11", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(40,  "R11", 1'b1, M0, 1'b0, 1'b0, 1'b0, 1'b1);
      push(41,  "R11", 1'b1, M5, 1'b0, 1'b1, 1'b1, 1'b0);
      push(50,  "R11", 1'b1, M5, 1'b0, 1'b1, 1'b1, 1'b0);
      push(60,  "R11", 1'b1, M5, 1'b0, 1'b1, 1'b1, 1'b0);
      push(61,  "R11", 1'b1, M6, 1'b1, 1'b1, 1'b1, 1'b0);
      push(100, "R11", 1'b1, M6, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_cyc(10);
      dcp_nodata = 1'b0;
      wait_cyc(95);

      if (sbq.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: act %0d items left exp 0", sbq.size());
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: act hung exp finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule